// File: doc/BRIEF.md
# Character Display Controller Core

This block models the controller that sits behind a character LCD's parallel processor bus. A host drives a strobe, a data/instruction select line, a read/write line and an 8-bit bus. The block acts on each access when the strobe falls. Instruction writes go through a priority decoder into a small set of actions. Data accesses move bytes between the bus and one of two on-chip stores, an 80-entry display store or a 64-entry glyph-pattern store, at the position held in a 7-bit address counter.

Every accepted access holds a busy flag for a set number of clock cycles. That number comes from the system clock frequency and the access's nominal execution time. The host polls a status byte to learn when the next access may go. Read data is presented on a separate output together with an output-enable, so a tristate pad outside the block can drive the shared bus.

Top module: `charlcd_ctrl`

## Requirements
- R1: An access is acted on at the first clock edge after `strobe_i` is seen falling. It uses the `is_data_i`, `is_read_i` and `bus_i` values present at that edge. The encoding is: `is_data_i`=0 with `is_read_i`=0 is an instruction write; 0 with 1 is a status read; 1 with 0 writes `bus_i` into the selected store at the counter; 1 with 1 reads the selected store at the counter.
- R2: While `strobe_i`=1, `is_read_i`=1 and `is_data_i`=0, `bus_o` is the status byte: bit 7 is the busy flag and bits 6..0 are the address counter. A status read never starts a busy period and never moves the counter.
- R3: `bus_oe` is 1 only while `strobe_i`=1 and `is_read_i`=1; otherwise it is 0.
- R4: An instruction is recognised by the highest set bit of its byte. Bit 0 means clear; bit 1 means home; bit 2 means entry mode, with bit 1 as the step direction (1 = up); bit 3 means display control; bit 4 means shift, with bit 3 selecting display (1) or cursor (0) and bit 2 the direction (1 = right); bit 5 means function set; bit 6 means glyph address (bits 5..0); bit 7 means display address (bits 6..0). The byte 0x00 has no effect and does not set busy.
- R5: Clear writes 0x20 to all 80 display entries, sets the counter to 0 and selects the display store. The glyph store is left unchanged.
- R6: Home sets the counter to 0 and selects the display store. Neither store changes.
- R7: A glyph-address instruction selects the glyph store and a display-address instruction selects the display store, each loading the counter. The glyph store keeps the low 5 bits of each byte written, and its reads return 0 in bits 7..5. Display positions 80..127 ignore writes and read back as 0x20.
- R8: After each accepted data read or write, the counter moves by one in the entry-mode direction. In the display store it wraps from 79 to 0 going up and from 0 to 79 going down. In the glyph store it wraps modulo 64.
- R9: A cursor shift moves the counter by one in the direction of bit 2, with the same wrapping as R8. A display shift leaves the counter unchanged.
- R10: The busy period lasts ceil(CLK_HZ × t) clock cycles after the acting edge. t is 1.53 ms for clear and home, 39 us for the other instructions and 43 us for data reads and writes.
- R11: While busy, instruction writes and data reads and writes are ignored. Status reads are still answered.
- R12: The counter step from R8 or R9 is applied at the edge that ends the busy period. A status read during the busy period returns the value from before the step.
- R13: After reset the counter is 0, the block is idle, the display store is selected, the step direction is up, every display entry holds 0x20 and every glyph entry holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Bus strobe; the access takes effect on its falling edge |
| is_data_i | input | 1 | 1 = data store access, 0 = instruction or status |
| is_read_i | input | 1 | 1 = read, 0 = write |
| bus_i | input | 8 | Write data or instruction byte |
| bus_o | output | 8 | Status byte or read data |
| bus_oe | output | 1 | Output enable for an external tristate driver |

## Verification
Writes take effect one clock after the bench lowers the strobe, so a busy period starts with N cycles remaining at the negative edge that ends a write. A status read samples `bus_o` one clock after it raises the strobe. By waiting N-3 cycles before a status read, the bench samples with exactly two cycles left, when the flag must be 1. The next status read samples at the cycle the period ends, when the flag must be 0 and any deferred counter step must be visible. Read data and enables are combinational in the strobe, so they are checked in the same cycle the strobe is raised. Each table step waits the longest busy time before the next access.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

   typedef enum logic [3:0] {
      OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISP,
      OP_SHIFT, OP_FUNC, OP_SET_CG, OP_SET_DD
   } lcd_op_e;

   typedef enum logic [1:0] {
      T_NONE, T_SHORT, T_LONG, T_DATA
   } tcls_e;

   // Round a duration in ns up to whole cycles of a clock in Hz.
   function automatic int unsigned ns_to_cycles(input longint unsigned hz,
                                                input longint unsigned ns);
      return int'((hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/charlcd_decode.sv
module charlcd_decode
   import charlcd_pkg::*;
(
   input  logic [7:0] code,
   output lcd_op_e    op,
   output tcls_e      tcls
);

   always_comb begin
      casez (code)
         8'b1???????: op = OP_SET_DD;
         8'b01??????: op = OP_SET_CG;
         8'b001?????: op = OP_FUNC;
         8'b0001????: op = OP_SHIFT;
         8'b00001???: op = OP_DISP;
         8'b000001??: op = OP_ENTRY;
         8'b0000001?: op = OP_HOME;
         8'b00000001: op = OP_CLEAR;
         default:     op = OP_NONE;
      endcase
   end

   always_comb begin
      case (op)
         OP_NONE:           tcls = T_NONE;
         OP_CLEAR, OP_HOME: tcls = T_LONG;
         default:           tcls = T_SHORT;
      endcase
   end

endmodule

// File: rtl/charlcd_busy.sv
module charlcd_busy
   import charlcd_pkg::*;
#(
   parameter int unsigned CW        = 12,
   parameter int unsigned LONG_CYC  = 1530,
   parameter int unsigned SHORT_CYC = 39,
   parameter int unsigned DATA_CYC  = 43
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  tcls_e         tcls,
   output logic          busy,
   output logic          last,
   output logic [CW-1:0] cnt
);

   logic [CW-1:0] load;

   always_comb begin
      case (tcls)
         T_LONG:  load = CW'(LONG_CYC);
         T_SHORT: load = CW'(SHORT_CYC);
         T_DATA:  load = CW'(DATA_CYC);
         default: load = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start)          cnt <= load;
      else if (cnt != '0)      cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
   assign last = (cnt == CW'(1));

endmodule

// File: rtl/charlcd_addr.sv
module charlcd_addr #(
   parameter int unsigned AW       = 7,
   parameter int unsigned CGW      = 6,
   parameter int unsigned DD_DEPTH = 80
) (
   input  logic [AW-1:0] ac,
   input  logic          up,
   input  logic          cg_sel,
   output logic [AW-1:0] nxt
);

   localparam logic [AW-1:0] DD_LAST = AW'(DD_DEPTH - 1);

   logic [CGW-1:0] cg_lo;

   always_comb begin
      cg_lo = up ? (ac[CGW-1:0] + CGW'(1)) : (ac[CGW-1:0] - CGW'(1));
      if (cg_sel)
         nxt = AW'(cg_lo);
      else if (up)
         nxt = (ac >= DD_LAST) ? '0 : ac + AW'(1);
      else
         nxt = (ac == '0) ? DD_LAST : ac - AW'(1);
   end

endmodule

// File: rtl/charlcd_ctrl.sv
module charlcd_ctrl
   import charlcd_pkg::*;
#(
   parameter int unsigned CLK_HZ   = 200_000_000,
   parameter int unsigned DD_DEPTH = 80,
   parameter int unsigned CG_DEPTH = 64,
   parameter int unsigned CG_BITS  = 5,
   parameter logic [7:0]  BLANK    = 8'h20,
   parameter int unsigned LONG_NS  = 1_530_000,
   parameter int unsigned SHORT_NS = 39_000,
   parameter int unsigned DATA_NS  = 43_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strobe_i,
   input  logic       is_data_i,
   input  logic       is_read_i,
   input  logic [7:0] bus_i,
   output logic [7:0] bus_o,
   output logic       bus_oe
);

   localparam int unsigned AW        = $clog2(DD_DEPTH);
   localparam int unsigned CGW       = $clog2(CG_DEPTH);
   localparam int unsigned LONG_CYC  = ns_to_cycles(CLK_HZ, LONG_NS);
   localparam int unsigned SHORT_CYC = ns_to_cycles(CLK_HZ, SHORT_NS);
   localparam int unsigned DATA_CYC  = ns_to_cycles(CLK_HZ, DATA_NS);
   localparam int unsigned CW        = $clog2(LONG_CYC + 1);

   // Elaboration-time parameter checks
   if (AW > 7) begin : g_bad_aw
      initial $fatal(1, "display depth needs more than 7 address bits");
   end
   if (CG_DEPTH != (1 << CGW) || CGW >= AW) begin : g_bad_cg
      initial $fatal(1, "glyph depth must be a power of two below display range");
   end
   if (CG_BITS < 1 || CG_BITS > 8) begin : g_bad_bits
      initial $fatal(1, "glyph width out of range");
   end
   if (LONG_CYC < SHORT_CYC || LONG_CYC < DATA_CYC || SHORT_CYC < 2) begin : g_bad_t
      initial $fatal(1, "execution times inconsistent");
   end

   logic              e_q, fall;
   logic [AW-1:0]     ac, ac_nxt;
   logic              cg_sel, inc, pend, pend_up;
   lcd_op_e           op;
   tcls_e             dec_tcls, tcls;
   logic              busy, last;
   logic [CW-1:0]     busy_cnt;
   logic              wr_ins, wr_dat, rd_dat, go_ins, go_dat, step_now, dd_ok;
   logic [7:0]        dd_mem [DD_DEPTH];
   logic [CG_BITS-1:0] cg_mem [CG_DEPTH];
   logic [7:0]        cg_rd, rd_byte;

   assign fall     = e_q & ~strobe_i;
   assign wr_ins   = fall & ~is_data_i & ~is_read_i;
   assign wr_dat   = fall &  is_data_i & ~is_read_i;
   assign rd_dat   = fall &  is_data_i &  is_read_i;
   assign go_ins   = wr_ins & ~busy & (op != OP_NONE);
   assign go_dat   = (wr_dat | rd_dat) & ~busy;
   assign step_now = pend & last;
   assign tcls     = go_dat ? T_DATA : dec_tcls;
   assign dd_ok    = (ac < AW'(DD_DEPTH));

   charlcd_decode u_dec (.code(bus_i), .op(op), .tcls(dec_tcls));

   charlcd_busy #(
      .CW(CW), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC), .DATA_CYC(DATA_CYC)
   ) u_busy (
      .clk(clk), .rst_n(rst_n), .start(go_ins | go_dat), .tcls(tcls),
      .busy(busy), .last(last), .cnt(busy_cnt)
   );

   charlcd_addr #(.AW(AW), .CGW(CGW), .DD_DEPTH(DD_DEPTH)) u_addr (
      .ac(ac), .up(pend_up), .cg_sel(cg_sel), .nxt(ac_nxt)
   );

   // Control state: counter, store select, direction, deferred step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q     <= 1'b0;
         ac      <= '0;
         cg_sel  <= 1'b0;
         inc     <= 1'b1;
         pend    <= 1'b0;
         pend_up <= 1'b1;
      end else begin
         e_q <= strobe_i;
         if (step_now) begin
            ac   <= ac_nxt;
            pend <= 1'b0;
         end
         if (go_ins) begin
            case (op)
               OP_CLEAR, OP_HOME: begin
                  ac     <= '0;
                  cg_sel <= 1'b0;
               end
               OP_ENTRY: inc <= bus_i[1];
               OP_SHIFT: if (!bus_i[3]) begin
                  pend    <= 1'b1;
                  pend_up <= bus_i[2];
               end
               OP_SET_CG: begin
                  ac     <= AW'(bus_i[CGW-1:0]);
                  cg_sel <= 1'b1;
               end
               OP_SET_DD: begin
                  ac     <= bus_i[AW-1:0];
                  cg_sel <= 1'b0;
               end
               default: ;
            endcase
         end
         if (go_dat) begin
            pend    <= 1'b1;
            pend_up <= inc;
         end
      end
   end

   // Storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DD_DEPTH); i++) dd_mem[i] <= BLANK;
         for (int j = 0; j < int'(CG_DEPTH); j++) cg_mem[j] <= '0;
      end else if (go_ins && op == OP_CLEAR) begin
         for (int i = 0; i < int'(DD_DEPTH); i++) dd_mem[i] <= BLANK;
      end else if (go_dat && wr_dat) begin
         if (cg_sel)     cg_mem[ac[CGW-1:0]] <= bus_i[CG_BITS-1:0];
         else if (dd_ok) dd_mem[ac] <= bus_i;
      end
   end

   if (CG_BITS < 8) begin : g_cg_pad
      assign cg_rd = {{(8 - CG_BITS){1'b0}}, cg_mem[ac[CGW-1:0]]};
   end else begin : g_cg_full
      assign cg_rd = cg_mem[ac[CGW-1:0]];
   end

   assign rd_byte = cg_sel ? cg_rd : (dd_ok ? dd_mem[ac] : BLANK);
   assign bus_o   = is_data_i ? rd_byte : {busy, 7'(ac)};
   assign bus_oe  = strobe_i & is_read_i;

endmodule

// File: rtl/charlcd_chk.sv
module charlcd_chk #(
   parameter int unsigned AW       = 7,
   parameter int unsigned CW       = 12,
   parameter int unsigned CG_DEPTH = 64,
   parameter int unsigned LONG_CYC = 1530,
   parameter int unsigned DATA_CYC = 43
) (
   input logic          clk,
   input logic          rst_n,
   input logic          strobe_i,
   input logic          is_data_i,
   input logic          is_read_i,
   input logic [7:0]    bus_i,
   input logic [7:0]    bus_o,
   input logic [CW-1:0] busy_cnt,
   input logic [AW-1:0] ac,
   input logic          cg_sel
);

   logic e_prev, fall_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_prev <= 1'b0;
      else        e_prev <= strobe_i;
   end
   assign fall_c = e_prev & ~strobe_i;

   // R2
   status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && is_read_i && !is_data_i) |-> (bus_o[7] == (busy_cnt != '0)));

   // R11
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt > CW'(1) && fall_c && !(!is_data_i && is_read_i))
      |=> ($stable(ac) && $stable(cg_sel)));

   // R10
   data_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt == '0 && fall_c && is_data_i) |=> (busy_cnt == CW'(DATA_CYC)));

   // R5
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt == '0 && fall_c && !is_data_i && !is_read_i && bus_i == 8'h01)
      |=> (ac == '0 && !cg_sel));

   // R8
   cg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cg_sel |-> (ac < AW'(CG_DEPTH)));

   // R10
   busy_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt <= CW'(LONG_CYC));

endmodule

bind charlcd_ctrl charlcd_chk #(
   .AW(AW), .CW(CW), .CG_DEPTH(CG_DEPTH), .LONG_CYC(LONG_CYC), .DATA_CYC(DATA_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .is_data_i(is_data_i),
   .is_read_i(is_read_i), .bus_i(bus_i), .bus_o(bus_o), .busy_cnt(busy_cnt),
   .ac(ac), .cg_sel(cg_sel)
);

// File: tb/charlcd_ctrl_test.sv
`timescale 1ns/1ps
module charlcd_ctrl_test;

   localparam int unsigned HZ    = 1_000_000;
   // Cycle counts worked out from R10 at HZ: ceil(1e6 * t)
   localparam int LONG  = 1530;
   localparam int SHORT = 39;
   localparam int DATA  = 43;

   typedef struct packed {
      logic       rs;
      logic       rw;
      logic [7:0] d;
      logic       chk;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b0, 8'h06, 1'b0, 8'h00, 4'd4},  // entry: up
      '{1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b0, 8'h41, 1'b0, 8'h00, 4'd1},
      '{1'b1, 1'b0, 8'h42, 1'b0, 8'h00, 4'd1},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 4'd8},  // R8 two steps up
      '{1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h41, 4'd1},  // R1 read back
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h42, 4'd1},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 4'd8},
      '{1'b0, 1'b0, 8'h04, 1'b0, 8'h00, 4'd4},  // entry: down
      '{1'b0, 1'b0, 8'h80, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b0, 8'h5A, 1'b0, 8'h00, 4'd1},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h4F, 4'd8},  // R8 0 -> 79
      '{1'b0, 1'b0, 8'h40, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 4'd7},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h3F, 4'd8},  // R8 glyph 0 -> 63
      '{1'b0, 1'b0, 8'h06, 1'b0, 8'h00, 4'd4},
      '{1'b0, 1'b0, 8'h7F, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b0, 8'h0E, 1'b0, 8'h00, 4'd1},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd8},  // R8 glyph 63 -> 0
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h1F, 4'd7},  // R7 low 5 bits kept
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h01, 4'd8},
      '{1'b0, 1'b0, 8'h14, 1'b0, 8'h00, 4'd9},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h02, 4'd9},  // R9 cursor right
      '{1'b0, 1'b0, 8'h10, 1'b0, 8'h00, 4'd9},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h01, 4'd9},  // R9 cursor left
      '{1'b0, 1'b0, 8'h18, 1'b0, 8'h00, 4'd9},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h01, 4'd9},  // R9 display shift
      '{1'b0, 1'b0, 8'h02, 1'b0, 8'h00, 4'd6},
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h5A, 4'd6},  // R6 contents kept
      '{1'b0, 1'b0, 8'hCF, 1'b0, 8'h00, 4'd7},
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h20, 4'd7},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd8},  // R8 79 -> 0
      '{1'b0, 1'b0, 8'h01, 1'b0, 8'h00, 4'd5},
      '{1'b0, 1'b1, 8'h00, 1'b1, 8'h00, 4'd5},  // R5 counter 0
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h20, 4'd5},  // R5 blanked
      '{1'b0, 1'b0, 8'hCF, 1'b0, 8'h00, 4'd5},
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h20, 4'd5},
      '{1'b0, 1'b0, 8'h40, 1'b0, 8'h00, 4'd5},
      '{1'b1, 1'b1, 8'h00, 1'b1, 8'h1F, 4'd5}   // R5 glyph kept
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_i = 1'b0;
   logic       is_data_i = 1'b0;
   logic       is_read_i = 1'b0;
   logic [7:0] bus_i = 8'h00;
   logic [7:0] bus_o;
   logic       bus_oe;
   int         nchk = 0;
   int         nerr = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   charlcd_ctrl #(.CLK_HZ(HZ)) uut (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .is_data_i(is_data_i),
      .is_read_i(is_read_i), .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic rs, input logic [7:0] d);
      is_data_i = rs; is_read_i = 1'b0; bus_i = d; strobe_i = 1'b1;
      @(negedge clk);
      strobe_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic rs, output logic [7:0] v, output logic oe);
      is_data_i = rs; is_read_i = 1'b1; strobe_i = 1'b1;
      @(negedge clk);
      v = bus_o; oe = bus_oe;
      strobe_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      logic       oe;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R3 enable low with strobe low
      check("R3 idle oe", {7'd0, bus_oe}, 8'h01 ^ 8'h01);
      // R13 reset state via status, R3 enable during read
      bus_rd(1'b0, v, oe);
      check("R13 status after reset", v, 8'h00);
      check("R3 oe during read", {7'd0, oe}, 8'h01);
      bus_rd(1'b1, v, oe);
      check("R13 blank display", v, 8'h20);
      idle(LONG + 4);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].rw) begin
            bus_rd(VEC[i].rs, v, oe);
            if (VEC[i].chk) check($sformatf("R%0d step %0d", VEC[i].req, i), v, VEC[i].exp);
         end else begin
            bus_wr(VEC[i].rs, VEC[i].d);
         end
         idle(LONG + 4);
      end

      // R10 short instruction boundary
      bus_wr(1'b0, 8'h90);
      idle(SHORT - 3);
      bus_rd(1'b0, v, oe);
      check("R10 short still busy", v, 8'h90);
      bus_rd(1'b0, v, oe);
      check("R10 short ended", v, 8'h10);

      // R10 long instruction boundary
      bus_wr(1'b0, 8'h02);
      idle(LONG - 3);
      bus_rd(1'b0, v, oe);
      check("R10 long still busy", v, 8'h80);
      bus_rd(1'b0, v, oe);
      check("R10 long ended", v, 8'h00);

      // R12 deferred step across a data write
      bus_wr(1'b0, 8'h85);
      idle(LONG + 4);
      bus_wr(1'b1, 8'h33);
      idle(DATA - 3);
      bus_rd(1'b0, v, oe);
      check("R12 old counter while busy", v, 8'h85);
      bus_rd(1'b0, v, oe);
      check("R12 stepped after busy", v, 8'h06);
      idle(4);

      // R11 accesses ignored while busy, status still answered
      bus_wr(1'b0, 8'h88);
      bus_wr(1'b0, 8'hC4);
      bus_wr(1'b1, 8'h77);
      bus_rd(1'b0, v, oe);
      check("R11 status while busy", v, 8'h88);
      idle(LONG + 4);
      bus_rd(1'b0, v, oe);
      check("R11 address write dropped", v, 8'h08);
      bus_rd(1'b1, v, oe);
      check("R11 data write dropped", v, 8'h20);
      idle(LONG + 4);

      // R4 zero byte is no instruction
      bus_wr(1'b0, 8'h00);
      bus_rd(1'b0, v, oe);
      check("R4 zero byte no busy", v, 8'h09);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200_000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule